// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Engine

This block is a single-channel copy engine. It moves a series of buffers whose parameters sit in a linked chain of descriptors in system memory. Software does three things before it starts the channel: it sets a destination start address, it places the address of the first descriptor in the chain-pointer register, and it sets the global enable. Writing the channel start bit then begins the work.

For each descriptor the engine reads all five descriptor words, and the channel registers are reloaded from them. The engine then copies the buffer one 32-bit word at a time. Each word is a read from the source address followed by a write to the destination address, and both addresses step by 4 after the pair. When the buffer is done, the engine writes the updated control word back into the descriptor it came from, marked done. It then follows the chain pointer to the next descriptor.

The destination word inside each descriptor is read but never used. The destination therefore runs on without a break from one buffer to the next, so a chain fills one contiguous region. A chain pointer of zero ends the chain. At that point the engine drops the channel enable and raises a sticky completion flag.

Top module: `llDmaEngine`

## Requirements
- R1: After reset the engine is idle. `memReq` and `bufDone` are low, the control register (index 0) reads 0 and the status register (index 3) reads 0.
- R2: No memory request is issued unless both bits are set in the control register: global enable (bit 0) and channel start (bit 1). Setting the channel start alone leaves `memReq` low, and bit 1 stays readable as 1.
- R3: A descriptor fetch reads five words at consecutive addresses from the descriptor base: +0 source, +4 destination, +8 control A, +12 control B, +16 next pointer. Control B is then readable at register index 5.
- R4: A buffer moves N words, where N is control A bits 15:0. Each word is read at the source address and written at the destination address. Both addresses advance by 4 per word, and nothing is written past the destination end.
- R5: The destination word of a descriptor is ignored. The destination register (index 1) continues from the end of the previous buffer, and after a buffer it reads start + 4·N.
- R6: After each buffer, exactly one word is written back: control A, at descriptor base +8. Bit 31 (done) is set, bits 15:0 (remaining count) read 0 and bits 30:16 are unchanged. The other descriptor words are left as they are.
- R7: A size field of 0 produces no data beats. Only the five descriptor reads and the write-back take place.
- R8: `bufDone` pulses high for exactly one cycle after each accepted write-back, once per descriptor.
- R9: When the chain pointer is zero, the channel start bit reads 0 after the write-back, and `xferIrq` and status bit 0 go high. A read of the status register clears the flag.
- R10: While `memReq` is high and `memReady` is low, the request, address and write-enable hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe (clears status on index 3) |
| regAddr | input | 3 | Register index: 0 control, 1 destination, 2 chain pointer, 3 status, 4 source (ro), 5 control B (ro) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Memory read data, valid with memReady |
| memReady | input | 1 | Access accepted this cycle |
| bufDone | output | 1 | One-cycle pulse per finished buffer |
| xferIrq | output | 1 | Sticky chain-complete flag |

## Verification
The bench builds the engine with the default 32-bit address and 16-bit size field against a 1 KB word-array memory. With those settings every descriptor, source and destination address is a real memory location, so write-backs and stray writes show up in the array. Buffer sizes of 0 to 8 words are used, with ready either always high or toggling. These sizes cover the zero-beat buffer, the single-word buffer where the first beat is also the last, and waited accesses in every state. A three-descriptor chain with an empty middle buffer shows that the destination carries over across buffers.

// File: rtl/llDmaPkg.sv
package llDmaPkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 5;
  localparam int DONE_BIT   = 31;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_READ, ST_WRITE, ST_WBACK} dmaState_t;
  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST, SEL_WB} addrSel_t;

  typedef struct packed {
    logic     req;
    logic     we;
    addrSel_t sel;
    logic     start;
    logic     fetchAck;
    logic     dataAck;
    logic     writeAck;
    logic     wbAck;
    logic     chainNext;
    logic     chainEnd;
  } dmaStrobe_t;
endpackage

// File: rtl/llDmaCtrl.sv
module llDmaCtrl
  import llDmaPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gEn,
  input  logic       chEn,
  input  logic       fetchLast,
  input  logic       sizeZero,
  input  logic       lastWord,
  input  logic       nextZero,
  input  logic       memReady,
  output dmaStrobe_t stb
);
  dmaState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    stb.sel   = SEL_DESC;
    unique case (state)
      ST_IDLE: begin
        if (gEn && chEn) begin
          stb.start = 1'b1;
          stateNext = ST_FETCH;
        end
      end
      ST_FETCH: begin
        stb.req = 1'b1;
        stb.sel = SEL_DESC;
        if (memReady) begin
          stb.fetchAck = 1'b1;
          if (fetchLast) stateNext = sizeZero ? ST_WBACK : ST_READ;
        end
      end
      ST_READ: begin
        stb.req = 1'b1;
        stb.sel = SEL_SRC;
        if (memReady) begin
          stb.dataAck = 1'b1;
          stateNext   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        stb.req = 1'b1;
        stb.we  = 1'b1;
        stb.sel = SEL_DST;
        if (memReady) begin
          stb.writeAck = 1'b1;
          stateNext    = lastWord ? ST_WBACK : ST_READ;
        end
      end
      ST_WBACK: begin
        stb.req = 1'b1;
        stb.we  = 1'b1;
        stb.sel = SEL_WB;
        if (memReady) begin
          stb.wbAck = 1'b1;
          if (nextZero) begin
            stb.chainEnd = 1'b1;
            stateNext    = ST_IDLE;
          end else begin
            stb.chainNext = 1'b1;
            stateNext     = ST_FETCH;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !gEn) |=> (state == ST_IDLE));
endmodule

// File: rtl/llDmaPath.sv
module llDmaPath
  import llDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        stb,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [2:0]        regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReady,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              bufDone,
  output logic              xferIrq,
  output logic              gEn,
  output logic              chEn,
  output logic              fetchLast,
  output logic              sizeZero,
  output logic              lastWord,
  output logic              nextZero
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] WB_OFFS = ADDR_W'(8);

  logic [ADDR_W-1:0] srcAddr, dstAddr, nextPtr, descBase;
  logic [WORD_W-1:0] ctrlA, ctrlB, dataBuf, wbWord;
  logic [IDX_W-1:0]  fetchIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      nextPtr  <= '0;
      descBase <= '0;
      ctrlA    <= '0;
      ctrlB    <= '0;
      dataBuf  <= '0;
      fetchIdx <= '0;
      gEn      <= 1'b0;
      chEn     <= 1'b0;
      xferIrq  <= 1'b0;
      bufDone  <= 1'b0;
    end else begin
      bufDone <= stb.wbAck;
      if (regWe) begin
        case (regAddr)
          3'd0: begin
            gEn <= regWdata[0];
            if (regWdata[1]) chEn <= 1'b1;
          end
          3'd1: dstAddr <= regWdata[ADDR_W-1:0];
          3'd2: nextPtr <= regWdata[ADDR_W-1:0];
          default: ;
        endcase
      end
      if (stb.chainEnd) begin
        chEn    <= 1'b0;
        xferIrq <= 1'b1;
      end else if (regRe && regAddr == 3'd3) begin
        xferIrq <= 1'b0;
      end
      if (stb.start || stb.chainNext) begin
        descBase <= nextPtr;
        fetchIdx <= '0;
      end
      if (stb.fetchAck) begin
        case (fetchIdx)
          IDX_W'(0): srcAddr <= memRdata[ADDR_W-1:0];
          IDX_W'(2): ctrlA   <= memRdata;
          IDX_W'(3): ctrlB   <= memRdata;
          IDX_W'(4): nextPtr <= memRdata[ADDR_W-1:0];
          default: ;
        endcase
        fetchIdx <= fetchIdx + 1'b1;
      end
      if (stb.dataAck) dataBuf <= memRdata;
      if (stb.writeAck) begin
        srcAddr             <= srcAddr + STEP;
        dstAddr             <= dstAddr + STEP;
        ctrlA[SIZE_W-1:0]   <= ctrlA[SIZE_W-1:0] - 1'b1;
      end
      if (stb.wbAck) ctrlA[DONE_BIT] <= 1'b1;
    end
  end

  always_comb begin
    wbWord           = ctrlA;
    wbWord[DONE_BIT] = 1'b1;
  end

  always_comb begin
    unique case (stb.sel)
      SEL_DESC: memAddr = descBase + (ADDR_W'(fetchIdx) << 2);
      SEL_SRC:  memAddr = srcAddr;
      SEL_DST:  memAddr = dstAddr;
      default:  memAddr = descBase + WB_OFFS;
    endcase
  end

  assign memReq   = stb.req;
  assign memWe    = stb.we;
  assign memWdata = (stb.sel == SEL_WB) ? wbWord : dataBuf;

  assign fetchLast = (fetchIdx == IDX_W'(DESC_WORDS - 1));
  assign sizeZero  = (ctrlA[SIZE_W-1:0] == '0);
  assign lastWord  = (ctrlA[SIZE_W-1:0] == SIZE_W'(1));
  assign nextZero  = (nextPtr == '0);

  always_comb begin
    case (regAddr)
      3'd0:    regRdata = {30'b0, chEn, gEn};
      3'd1:    regRdata = WORD_W'(dstAddr);
      3'd2:    regRdata = WORD_W'(nextPtr);
      3'd3:    regRdata = {31'b0, xferIrq};
      3'd4:    regRdata = WORD_W'(srcAddr);
      3'd5:    regRdata = ctrlB;
      default: regRdata = '0;
    endcase
  end

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R4
  dst_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeAck |=> (dstAddr == $past(dstAddr) + STEP));

  // R6
  wb_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && stb.sel == SEL_WB) |-> (memWdata[DONE_BIT] && memWdata[SIZE_W-1:0] == '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufDone |=> !bufDone);

  // R9
  chain_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.chainEnd |=> (!chEn && xferIrq));
endmodule

// File: rtl/llDmaEngine.sv
module llDmaEngine
  import llDmaPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic              regRe,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memReady,
  output logic              bufDone,
  output logic              xferIrq
);
  dmaStrobe_t stb;
  logic gEn, chEn, fetchLast, sizeZero, lastWord, nextZero;

  llDmaCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .gEn(gEn), .chEn(chEn), .fetchLast(fetchLast),
    .sizeZero(sizeZero), .lastWord(lastWord), .nextZero(nextZero),
    .memReady(memReady), .stb(stb)
  );

  llDmaPath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memRdata(memRdata), .memReady(memReady),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .bufDone(bufDone), .xferIrq(xferIrq), .gEn(gEn), .chEn(chEn),
    .fetchLast(fetchLast), .sizeZero(sizeZero), .lastWord(lastWord),
    .nextZero(nextZero)
  );
endmodule

// File: tb/llDmaEngine_tb.sv
module llDmaEngine_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] VEC [0:3] = '{ {8'd1, 1'b0}, {8'd3, 1'b1}, {8'd5, 1'b0}, {8'd8, 1'b1} };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0, regRe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe, bufDone, xferIrq;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        memReady = 1'b1;
  logic        stallMode = 1'b0;

  logic [31:0] mem [0:255];
  int checks = 0, errors = 0;
  int reqCnt, bufCnt, rdCnt, holdErr, pulseErr;
  logic [31:0] rdLog [0:63];
  logic prevPend, prevWe, prevBuf;
  logic [31:0] prevAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  llDmaEngine u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regRe(regRe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .memReady(memReady), .bufDone(bufDone), .xferIrq(xferIrq)
  );

  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (memReq && memWe && memReady) mem[memAddr[9:2]] <= memWdata;
  end

  always @(posedge clk) begin
    #2;
    memReady <= stallMode ? ~memReady : 1'b1;
  end

  always @(negedge clk) begin
    if (!rstN) begin
      reqCnt = 0; bufCnt = 0; rdCnt = 0; holdErr = 0; pulseErr = 0;
      prevPend = 1'b0; prevBuf = 1'b0; prevWe = 1'b0; prevAddr = '0;
    end else begin
      if (prevPend && !(memReq && memAddr == prevAddr && memWe == prevWe)) holdErr++;
      prevPend = memReq && !memReady;
      prevAddr = memAddr;
      prevWe   = memWe;
      if (memReq) reqCnt++;
      if (memReq && !memWe && memReady && rdCnt < 64) begin
        rdLog[rdCnt] = memAddr;
        rdCnt++;
      end
      if (bufDone && prevBuf) pulseErr++;
      if (bufDone) bufCnt++;
      prevBuf = bufDone;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regRe = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 + i;
  endtask

  task automatic putDesc(input int base, input int src, input int size,
                         input int attr, input int cb, input int nxt);
    mem[base/4]     = src;
    mem[base/4 + 1] = 32'h0000_03C0;
    mem[base/4 + 2] = {1'b0, attr[14:0], size[15:0]};
    mem[base/4 + 3] = cb;
    mem[base/4 + 4] = nxt;
  endtask

  task automatic runChan(input int first, output logic ok);
    logic [31:0] v;
    regWrite(3'd1, 32'h0000_0200);
    regWrite(3'd2, first);
    regWrite(3'd0, 32'h3);
    ok = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      regRead(3'd0, v);
      if (!v[1]) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic ok;
    int bad;
    clearMem();
    doReset();

    // R1 reset state
    chk("R1 memReq", {31'b0, memReq}, 32'h0);
    chk("R1 bufDone", {31'b0, bufDone}, 32'h0);
    regRead(3'd0, v); chk("R1 control", v, 32'h0);
    regRead(3'd3, v); chk("R1 status", v, 32'h0);

    // Table-driven single-buffer transfers
    for (int t = 0; t < 4; t++) begin
      int size;
      size = VEC[t][8:1];
      stallMode = VEC[t][0];
      clearMem();
      putDesc(32'h40, 32'h100, size, 15'h1357 + t, 32'hCAFE_0000 + t, 0);
      for (int i = 0; i < 16; i++) mem[64 + i] = 32'hA500_0000 + t * 256 + i;
      doReset();
      runChan(32'h40, ok);
      chk("R9 chain stopped", {31'b0, ok}, 32'h1);
      bad = 0;
      for (int i = 0; i < size; i++) if (mem[128 + i] !== 32'hA500_0000 + t * 256 + i) bad++;
      chk("R4 copied words", bad, 0);
      chk("R4 no write past end", mem[128 + size], 32'hDEAD_0000 + 128 + size);
      chk("R5 descriptor dst unused", mem[240], 32'hDEAD_0000 + 240);
      chk("R6 write-back word", mem[18], {1'b1, 15'h1357 + 15'(t), 16'h0});
      chk("R6 control B untouched", mem[19], 32'hCAFE_0000 + t);
      regRead(3'd1, v); chk("R5 dst register", v, 32'h200 + 4 * size);
      regRead(3'd5, v); chk("R3 control B reloaded", v, 32'hCAFE_0000 + t);
      bad = 0;
      for (int i = 0; i < 5; i++) if (rdLog[i] !== 32'h40 + 4 * i) bad++;
      chk("R3 fetch addresses", bad, 0);
      chk("R8 pulse count", bufCnt, 1);
      chk("R8 pulse width", pulseErr, 0);
      chk("R9 irq port", {31'b0, xferIrq}, 32'h1);
      regRead(3'd3, v); chk("R9 status set", v, 32'h1);
      regRead(3'd3, v); chk("R9 status cleared", v, 32'h0);
      chk("R10 request held under wait", holdErr, 0);
    end

    // R2 channel start without global enable
    stallMode = 1'b0;
    clearMem();
    doReset();
    regWrite(3'd2, 32'h40);
    regWrite(3'd0, 32'h2);
    repeat (20) @(negedge clk);
    chk("R2 no request", reqCnt, 0);
    regRead(3'd0, v); chk("R2 start bit kept", v, 32'h2);

    // R7 zero-size buffer
    clearMem();
    putDesc(32'h40, 32'h100, 0, 15'h0ABC, 32'h5555_0000, 0);
    doReset();
    runChan(32'h40, ok);
    chk("R7 finished", {31'b0, ok}, 32'h1);
    chk("R7 only descriptor reads", rdCnt, 5);
    chk("R7 dst untouched", mem[128], 32'hDEAD_0000 + 128);
    chk("R7 write-back", mem[18], {1'b1, 15'h0ABC, 16'h0});
    regRead(3'd1, v); chk("R7 dst register", v, 32'h200);
    chk("R8 zero-size pulse", bufCnt, 1);

    // Three-descriptor chain, middle buffer empty, waited accesses
    stallMode = 1'b1;
    clearMem();
    putDesc(32'h40, 32'h100, 3, 15'h0011, 32'hB0, 32'h60);
    putDesc(32'h60, 32'h140, 0, 15'h0022, 32'hB1, 32'h80);
    putDesc(32'h80, 32'h180, 4, 15'h0033, 32'hB2, 0);
    for (int i = 0; i < 48; i++) mem[64 + i] = 32'h7700_0000 + i;
    doReset();
    runChan(32'h40, ok);
    chk("R9 chain finished", {31'b0, ok}, 32'h1);
    bad = 0;
    for (int i = 0; i < 3; i++) if (mem[128 + i] !== 32'h7700_0000 + i) bad++;
    for (int i = 0; i < 4; i++) if (mem[131 + i] !== 32'h7700_0000 + 32 + i) bad++;
    chk("R5 contiguous destination", bad, 0);
    chk("R4 chain end bound", mem[135], 32'hDEAD_0000 + 135);
    chk("R6 wb first", mem[18], {1'b1, 15'h0011, 16'h0});
    chk("R6 wb second", mem[26], {1'b1, 15'h0022, 16'h0});
    chk("R6 wb third", mem[34], {1'b1, 15'h0033, 16'h0});
    chk("R6 next pointers kept", mem[20] ^ mem[28], 32'h60 ^ 32'h80);
    regRead(3'd1, v); chk("R5 dst after chain", v, 32'h21C);
    chk("R8 three pulses", bufCnt, 3);
    chk("R8 pulse width chain", pulseErr, 0);
    chk("R10 hold in chain", holdErr, 0);
    regRead(3'd3, v); chk("R9 status chain", v, 32'h1);
    chk("R9 irq cleared by read", {31'b0, xferIrq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule